// File: doc/BRIEF.md
# Nearest Three Beacon Tracker

The tracker accepts a stream of beacon reports, one per clock when a report strobe is high. Each report carries a 48-bit transmitter address, a 12-bit measured distance and the 12-bit X and Y coordinates that an upstream stage has already found for that address. The block keeps a table of three rows. Each row holds a transmitter's address, its coordinates and a smoothed distance, which is the mean of that transmitter's last four distance samples.

A report from a transmitter already in the table extends that row's sample history. A report from a new transmitter takes the lowest-numbered empty row. When no row is empty, the new transmitter displaces the row with the largest smoothed distance, but only if its own distance is strictly smaller. Otherwise the report is discarded. Distances are unsigned integers, and the smallest counts as best. A downstream position solver reads the three rows and starts work once a ready flag shows that all three rows hold data.

Top module: `n3t_tracker`

## Requirements
- R1: While rst_n is low, and directly after it is released, every row valid bit, address, coordinate and distance output reads zero and solver_ready_o is low.
- R2: A report whose address equals the address of a valid row pushes its distance into that row's four-entry history and drops the oldest entry. That row's row_dist_o becomes floor(sum of the last four samples / 4). No other row changes, and the result is visible after the clock edge that sampled the report.
- R3: On such a matching report, the matched row's X and Y outputs take the report's coordinates.
- R4: A report from an address held in no valid row, while some row is empty, loads the lowest-numbered empty row. The row becomes valid with the report's address and coordinates, and all four history entries hold the report's distance, so row_dist_o equals that distance.
- R5: A report from a new address while all rows are valid replaces the row with the largest smoothed distance, lowest row index on a tie, when the report's distance is strictly smaller than that row's smoothed distance. The replaced row is loaded as in R4.
- R6: A report from a new address while all rows are valid, whose distance is greater than or equal to the largest smoothed distance, leaves every output unchanged.
- R7: solver_ready_o is high exactly when all three row valid bits are high. Once high, it stays high until reset.
- R8: While rpt_valid_i is low, the table does not change, whatever the other report inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rpt_valid_i | input | 1 | Report strobe |
| rpt_addr_i | input | 48 | Transmitter address of the report |
| rpt_dist_i | input | 12 | Measured distance, unsigned |
| rpt_x_i | input | 12 | X coordinate for the address |
| rpt_y_i | input | 12 | Y coordinate for the address |
| row_valid_o | output | 3 | Valid bit per row, bit i for row i |
| row_addr_o | output | 144 | Row addresses, row i at bits [48i+47:48i] |
| row_x_o | output | 36 | Row X coordinates, row i at bits [12i+11:12i] |
| row_y_o | output | 36 | Row Y coordinates, row i at bits [12i+11:12i] |
| row_dist_o | output | 36 | Row smoothed distances, row i at bits [12i+11:12i] |
| solver_ready_o | output | 1 | All rows valid |

## Verification
Two decisions compete in the same cycle. A report can both match a stored address and arrive while the table is full, and the matched row may also be the one with the largest mean, which makes it the eviction victim. The bench provokes this on purpose with directed reports that hit the current worst row, with a small random address pool, and with distances set to equal the worst mean. A behavioural model compares every row after every clock, so a history update mistaken for an eviction, or an eviction on a tie, shows up at once.

// File: rtl/n3t_pkg.sv
package n3t_pkg;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_SHIFT,
    DEC_FILL,
    DEC_EVICT,
    DEC_DROP
  } n3t_dec_e;

endpackage

// File: rtl/n3t_row.sv
module n3t_row #(
  parameter int ADDR_W  = 48,
  parameter int DIST_W  = 12,
  parameter int COORD_W = 12,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DIST_W-1:0]  dist_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic [DIST_W-1:0]  avg_o
);

  localparam int SH_W  = $clog2(DEPTH);
  localparam int SUM_W = DIST_W + SH_W;

  logic                           valid_q, valid_d;
  logic [ADDR_W-1:0]              addr_q, addr_d;
  logic [COORD_W-1:0]             x_q, x_d, y_q, y_d;
  logic [DEPTH-1:0][DIST_W-1:0]   hist_q, hist_d;
  logic                           en;
  logic [SUM_W-1:0]               sum;

  assign en = load_i | shift_i;

  // next state
  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    x_d     = x_q;
    y_d     = y_q;
    hist_d  = hist_q;
    if (load_i) begin
      valid_d = 1'b1;
      addr_d  = addr_i;
      x_d     = x_i;
      y_d     = y_i;
      for (int k = 0; k < DEPTH; k++) hist_d[k] = dist_i;
    end else if (shift_i) begin
      x_d       = x_i;
      y_d       = y_i;
      hist_d[0] = dist_i;
      for (int k = 1; k < DEPTH; k++) hist_d[k] = hist_q[k-1];
    end
  end

  // state registers with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      x_q     <= '0;
      y_q     <= '0;
      hist_q  <= '0;
    end else if (en) begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      x_q     <= x_d;
      y_q     <= y_d;
      hist_q  <= hist_d;
    end
  end

  // mean of the history
  always_comb begin
    sum = '0;
    for (int k = 0; k < DEPTH; k++) sum = sum + SUM_W'(hist_q[k]);
  end

  assign avg_o   = DIST_W'(sum >> SH_W);
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign x_o     = x_q;
  assign y_o     = y_q;

  assert_load_mean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (avg_o == $past(dist_i)) && valid_o);

  assert_shift_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> valid_o && !load_i);

  assert_shift_keeps_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> $stable(addr_o) && valid_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i || shift_i) |=> $stable(addr_o) && $stable(avg_o) && $stable(valid_o)
                             && $stable(x_o) && $stable(y_o));

endmodule

// File: rtl/n3t_select.sv
module n3t_select
  import n3t_pkg::*;
#(
  parameter int ROWS   = 3,
  parameter int ADDR_W = 48,
  parameter int DIST_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rpt_valid_i,
  input  logic [ADDR_W-1:0]            rpt_addr_i,
  input  logic [DIST_W-1:0]            rpt_dist_i,
  input  logic [ROWS-1:0]              row_valid_i,
  input  logic [ROWS-1:0][ADDR_W-1:0]  row_addr_i,
  input  logic [ROWS-1:0][DIST_W-1:0]  row_avg_i,
  output logic [ROWS-1:0]              load_o,
  output logic [ROWS-1:0]              shift_o
);

  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ROWS-1:0]   hit;
  logic              hit_any, free_any;
  logic [IDX_W-1:0]  hit_idx, free_idx, worst_idx;
  logic [DIST_W-1:0] worst_avg;
  n3t_dec_e          dec;

  // address compare per row
  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign hit[g] = row_valid_i[g] && (row_addr_i[g] == rpt_addr_i);
  end

  assign hit_any  = |hit;
  assign free_any = ~&row_valid_i;

  // lowest-numbered hit and empty row
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (hit[i])         hit_idx  = IDX_W'(i);
      if (!row_valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  // largest mean, earliest row wins ties
  always_comb begin
    worst_idx = '0;
    worst_avg = row_avg_i[0];
    for (int i = 1; i < ROWS; i++) begin
      if (row_avg_i[i] > worst_avg) begin
        worst_avg = row_avg_i[i];
        worst_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!rpt_valid_i)                 dec = DEC_IDLE;
    else if (hit_any)                 dec = DEC_SHIFT;
    else if (free_any)                dec = DEC_FILL;
    else if (rpt_dist_i < worst_avg)  dec = DEC_EVICT;
    else                              dec = DEC_DROP;
  end

  always_comb begin
    load_o  = '0;
    shift_o = '0;
    case (dec)
      DEC_SHIFT: shift_o[hit_idx]  = 1'b1;
      DEC_FILL:  load_o[free_idx]  = 1'b1;
      DEC_EVICT: load_o[worst_idx] = 1'b1;
      default: ;
    endcase
  end

  assert_unique_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_i |-> $onehot0(hit));

  assert_fill_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|load_o) && !(&row_valid_i)) |-> ((load_o & row_valid_i) == '0));

  assert_evict_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(load_o & row_valid_i)) |-> ((&row_valid_i) && !hit_any));

  assert_idle_no_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid_i |-> ((load_o | shift_o) == '0));

endmodule

// File: rtl/n3t_tracker.sv
module n3t_tracker #(
  parameter int ADDR_W  = 48,
  parameter int DIST_W  = 12,
  parameter int COORD_W = 12,
  parameter int ROWS    = 3,
  parameter int DEPTH   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rpt_valid_i,
  input  logic [ADDR_W-1:0]             rpt_addr_i,
  input  logic [DIST_W-1:0]             rpt_dist_i,
  input  logic [COORD_W-1:0]            rpt_x_i,
  input  logic [COORD_W-1:0]            rpt_y_i,
  output logic [ROWS-1:0]               row_valid_o,
  output logic [ROWS-1:0][ADDR_W-1:0]   row_addr_o,
  output logic [ROWS-1:0][COORD_W-1:0]  row_x_o,
  output logic [ROWS-1:0][COORD_W-1:0]  row_y_o,
  output logic [ROWS-1:0][DIST_W-1:0]   row_dist_o,
  output logic                          solver_ready_o
);

  logic [ROWS-1:0] load, shift;

  n3t_select #(
    .ROWS   (ROWS),
    .ADDR_W (ADDR_W),
    .DIST_W (DIST_W)
  ) u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .rpt_valid_i (rpt_valid_i),
    .rpt_addr_i  (rpt_addr_i),
    .rpt_dist_i  (rpt_dist_i),
    .row_valid_i (row_valid_o),
    .row_addr_i  (row_addr_o),
    .row_avg_i   (row_dist_o),
    .load_o      (load),
    .shift_o     (shift)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    n3t_row #(
      .ADDR_W  (ADDR_W),
      .DIST_W  (DIST_W),
      .COORD_W (COORD_W),
      .DEPTH   (DEPTH)
    ) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load[g]),
      .shift_i (shift[g]),
      .addr_i  (rpt_addr_i),
      .dist_i  (rpt_dist_i),
      .x_i     (rpt_x_i),
      .y_i     (rpt_y_i),
      .valid_o (row_valid_o[g]),
      .addr_o  (row_addr_o[g]),
      .x_o     (row_x_o[g]),
      .y_o     (row_y_o[g]),
      .avg_o   (row_dist_o[g])
    );
  end

  assign solver_ready_o = &row_valid_o;

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    solver_ready_o |=> solver_ready_o);

  assert_one_row_per_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load | shift));

endmodule

// File: tb/n3t_tracker_bench.sv
module n3t_tracker_bench;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 rpt_valid;
  logic [47:0]          rpt_addr;
  logic [11:0]          rpt_dist, rpt_x, rpt_y;
  logic [2:0]           row_valid;
  logic [2:0][47:0]     row_addr;
  logic [2:0][11:0]     row_x, row_y, row_dist;
  logic                 ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          mv[3];
  logic [47:0] ma[3];
  int          mx[3], my[3];
  int          mh[3][4];

  always #5 clk = ~clk;

  n3t_tracker u_n3t_tracker (
    .clk            (clk),
    .rst_n          (rst_n),
    .rpt_valid_i    (rpt_valid),
    .rpt_addr_i     (rpt_addr),
    .rpt_dist_i     (rpt_dist),
    .rpt_x_i        (rpt_x),
    .rpt_y_i        (rpt_y),
    .row_valid_o    (row_valid),
    .row_addr_o     (row_addr),
    .row_x_o        (row_x),
    .row_y_o        (row_y),
    .row_dist_o     (row_dist),
    .solver_ready_o (ready)
  );

  function automatic int mavg(int r);
    return (mh[r][0] + mh[r][1] + mh[r][2] + mh[r][3]) / 4;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 3; r++) begin
      mv[r] = 0; ma[r] = '0; mx[r] = 0; my[r] = 0;
      for (int k = 0; k < 4; k++) mh[r][k] = 0;
    end
  endtask

  function automatic string model_apply(bit v, logic [47:0] a, int d, int x, int y);
    int hit, fr, w;
    if (!v) return "R8";
    hit = -1;
    for (int r = 0; r < 3; r++) if (hit < 0 && mv[r] && ma[r] == a) hit = r;
    if (hit >= 0) begin
      for (int k = 3; k > 0; k--) mh[hit][k] = mh[hit][k-1];
      mh[hit][0] = d; mx[hit] = x; my[hit] = y;
      return "R2";
    end
    fr = -1;
    for (int r = 0; r < 3; r++) if (fr < 0 && !mv[r]) fr = r;
    if (fr < 0) begin
      w = 0;
      for (int r = 1; r < 3; r++) if (mavg(r) > mavg(w)) w = r;
      if (d >= mavg(w)) return "R6";
      fr = w;
    end
    mv[fr] = 1; ma[fr] = a; mx[fr] = x; my[fr] = y;
    for (int k = 0; k < 4; k++) mh[fr][k] = d;
    return (mv[0] && mv[1] && mv[2] && w >= 0 && fr == w) ? "R5" : "R4";
  endfunction

  task automatic compare_all(string tag);
    string ctag;
    for (int r = 0; r < 3; r++) begin
      chk(tag, $sformatf("row%0d valid", r), row_valid[r], mv[r]);
      chk(tag, $sformatf("row%0d addr", r), row_addr[r], ma[r]);
      ctag = (tag == "R2") ? "R3" : tag;
      chk(ctag, $sformatf("row%0d x", r), row_x[r], mx[r]);
      chk(ctag, $sformatf("row%0d y", r), row_y[r], my[r]);
      chk(tag, $sformatf("row%0d dist", r), row_dist[r], mavg(r));
    end
    chk("R7", "solver_ready", ready, mv[0] && mv[1] && mv[2]);
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(bit v, logic [47:0] a, int d, int x, int y);
    string tag;
    rpt_valid = v; rpt_addr = a;
    rpt_dist = 12'(d); rpt_x = 12'(x); rpt_y = 12'(y);
    @(posedge clk);
    tag = model_apply(v, a, d, x, y);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rpt_valid = 1'b1; rpt_addr = 48'h1234; rpt_dist = 12'd7;
    model_clear();
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    rpt_valid = 1'b0;
    @(negedge clk);
    compare_all("R1");
  endtask

  localparam logic [47:0] A = 48'h0000_AAAA_0001;
  localparam logic [47:0] B = 48'h0000_AAAA_0002;
  localparam logic [47:0] C = 48'h0000_AAAA_0003;
  localparam logic [47:0] D = 48'h0000_AAAA_0004;
  localparam logic [47:0] E = 48'h0000_AAAA_0005;

  initial begin
    rst_n = 1'b0;
    rpt_valid = 0; rpt_addr = '0; rpt_dist = '0; rpt_x = '0; rpt_y = '0;
    model_clear();
    do_reset();

    // R8: idle with junk on the data inputs
    step(0, A, 55, 1, 2);
    step(0, B, 0, 3, 4);

    // R4: fills in row order, ready only at the third
    step(1, A, 100, 10, 11);
    step(1, B, 200, 20, 21);
    step(1, C, 4095, 30, 31);

    // R2/R3: history update on B with coordinate change
    step(1, B, 400, 22, 23);
    step(1, B, 0, 24, 25);
    step(1, B, 3, 26, 27);

    // R6: tie with worst mean is dropped
    step(1, D, 4095, 40, 41);
    // R5: strictly smaller displaces row holding C
    step(1, D, 4094, 40, 41);
    // matching report on the worst row must not evict
    step(1, D, 10, 42, 43);
    step(1, D, 4095, 44, 45);
    step(0, E, 1, 0, 0);

    // tie on largest mean: earliest row replaced
    for (int k = 0; k < 4; k++) step(1, A, 500, 10, 11);
    for (int k = 0; k < 4; k++) step(1, B, 500, 20, 21);
    for (int k = 0; k < 4; k++) step(1, D, 100, 40, 41);
    step(1, E, 499, 50, 51);

    // random mix over a small pool
    for (int n = 0; n < 3000; n++) begin
      logic [47:0] ra;
      int rd;
      ra = 48'h0000_AAAA_0000 | 48'($urandom_range(1, 7));
      case ($urandom_range(0, 3))
        0: rd = $urandom_range(0, 4095);
        1: rd = 4095;
        2: rd = $urandom_range(0, 15);
        default: rd = $urandom_range(200, 800);
      endcase
      step($urandom_range(0, 9) < 8, ra, rd, $urandom_range(0, 4095), $urandom_range(0, 4095));
    end

    // R1: reset while full
    do_reset();
    step(1, C, 77, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule